// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Channel with Handshake Lines

This block is one full-duplex asynchronous serial channel. A host writes a character into a single-entry transmit holding register and the transmitter sends it as a fixed frame: one start bit, eight data bits with the least significant bit first, and one stop bit. The receiver finds incoming frames, checks each stop bit, and places every character together with its framing-error flag into a four-entry buffer. The host reads the buffer from its head. Mark is logic 1 and space is logic 0.

For each direction, bit timing comes either from a shared 16X tick enable (`tick16_i`) or from that direction's own external 1X clock. The receiver samples on rising edges of its external clock. The transmitter launches each bit on falling edges of its external clock. A local loopback mode feeds the transmitter's serial stream straight into the receiver and holds the line output at mark.

The request-to-send output can drop automatically in two ways. It can follow transmitter activity, and it can be forced inactive while the receive buffer is full. The clear-to-send input holds back new characters. Active-low status pins report receive readiness or buffer fullness, and transmit readiness.

Top module: `serial_chan`

## Requirements
- R1: A frame is a low start bit, eight data bits with the LSB first, and a high stop bit. In internal timing, one bit lasts 16 cycles of `tick16_i`. This holds for both the transmitter and the receiver.
- R2: `txd_o` is 1 during reset, while the transmitter is idle, and while the transmitter is disabled.
- R3: While `cts_n_i` is 1, no new character starts. A character already on the line completes all ten bits.
- R4: In internal timing, the receiver confirms a start bit 8 ticks after the falling edge. If the line is high again at that point, the receiver discards the start and stores nothing.
- R5: If a frame's stop bit is sampled low, `rd_ferr_o` is 1 when that character reaches the buffer head. Otherwise `rd_ferr_o` is 0.
- R6: The receive buffer holds 4 characters in arrival order. `rx_ready_o` is 1 when the buffer holds at least one character, and `rx_full_o` is 1 when it holds four. A pulse on `rd_i` removes the head. A pulse on `rd_i` while the buffer is empty has no effect.
- R7: A character that completes while the buffer is full is discarded, and `overrun_o` is set. `overrun_o` stays 1 until `ovr_clr_i` is pulsed.
- R8: `tx_ready_o` is 1 when `tx_en_i` is 1 and the holding register is empty. A write made while `tx_ready_o` is 0 is ignored.
- R9: With `tx_ext_sel_i` at 1, `txd_o` changes only after falling edges of `ext_txclk_i`.
- R10: With `rx_ext_sel_i` at 1, the receiver samples one bit on each rising edge of `ext_rxclk_i`.
- R11: With `loopback_i` at 1, the transmitter's bit stream is fed to the receiver, `rxd_i` is ignored, and `txd_o` stays 1.
- R12: `rts_n_o` is a registered output. It is 0 when either `rts_req_i` is 1, or `rts_auto_tx_i` is 1 and the transmitter holds or sends a character. This is overridden: if `rts_auto_rx_i` is 1 and the buffer is full, `rts_n_o` is 1.
- R13: `rx_irq_n_o` is 0 when the buffer is non-empty (with `rx_irq_sel_i` at 0) or full (with `rx_irq_sel_i` at 1). `tx_rdy_n_o` is the inverse of `tx_ready_o`. Both pins are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | 16X bit-rate enable pulse |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| loopback_i | input | 1 | Local loopback mode |
| tx_ext_sel_i | input | 1 | Transmitter uses external 1X clock |
| rx_ext_sel_i | input | 1 | Receiver uses external 1X clock |
| ext_txclk_i | input | 1 | External transmit 1X clock |
| ext_rxclk_i | input | 1 | External receive 1X clock |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_n_i | input | 1 | Clear to send, active low |
| rts_req_i | input | 1 | Host request for RTS |
| rts_auto_tx_i | input | 1 | RTS follows transmitter activity |
| rts_auto_rx_i | input | 1 | RTS drops when buffer is full |
| rts_n_o | output | 1 | Request to send, active low |
| wr_i | input | 1 | Write transmit character |
| wdata_i | input | 8 | Transmit character |
| tx_ready_o | output | 1 | Holding register free |
| rd_i | input | 1 | Pop receive buffer head |
| rdata_o | output | 8 | Receive buffer head character |
| rd_ferr_o | output | 1 | Framing error of head character |
| rx_ready_o | output | 1 | Buffer non-empty |
| rx_full_o | output | 1 | Buffer full |
| overrun_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clear overrun flag |
| rx_irq_sel_i | input | 1 | Receive pin reports full (1) or ready (0) |
| rx_irq_n_o | output | 1 | Receive status pin, active low |
| tx_rdy_n_o | output | 1 | Transmit ready pin, active low |

## Verification
A receiver whose sample phase is off by a few ticks still passes on clean frames. It shows up only on the noise-pulse case and on back-to-back frames with a low stop bit, within the next frame. A wrong buffer pointer or count shows up as reordered or duplicated characters, or as early or missing full and overrun flags, by the fourth or fifth character. A transmitter that launches on the wrong external edge moves `txd_o` during the high phase of `ext_txclk_i`, within one bit period. The full sweep of all 256 codes through loopback exposes any data-bit misordering in the first character that contains that bit.

// File: rtl/chan_pkg.sv
package chan_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/chan_edge.sv
// Synchronizes an external 1X clock and emits a one-cycle strobe on the chosen edge.
module chan_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic strobe_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  generate
    if (RISING) begin : g_rise
      assign strobe_o = s2 & ~s3;
    end else begin : g_fall
      assign strobe_o = ~s2 & s3;
    end
  endgenerate
endmodule

// File: rtl/chan_tx.sv
module chan_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              cts_n_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ext_sel_i,
  input  logic              tick16_i,
  input  logic              ext_fall_i,
  output logic              line_o,
  output logic              ready_o,
  output logic              work_o
);
  localparam int CW  = $clog2(OVS);
  localparam int BCW = $clog2(DATA_W + 2);

  logic [CW-1:0]   ph;
  logic            hold_full;
  logic [DATA_W-1:0] hold_q;
  logic            busy;
  logic [BCW-1:0]  remain;
  logic [DATA_W:0] shreg;
  logic            bit_stb, start_now;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else if (tick16_i) ph <= (ph == CW'(OVS - 1)) ? '0 : ph + 1'b1;
  end

  assign bit_stb   = ext_sel_i ? ext_fall_i : (tick16_i && ph == CW'(OVS - 1));
  assign start_now = bit_stb && (!busy || remain == '0) && hold_full && en_i && !cts_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (start_now) hold_full <= 1'b0;
      if (wr_i && en_i && !hold_full) begin
        hold_full <= 1'b1;
        hold_q    <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      line_o <= 1'b1;
      remain <= '0;
      shreg  <= '1;
    end else if (bit_stb) begin
      if (busy && remain != '0) begin
        line_o <= shreg[0];
        shreg  <= {1'b1, shreg[DATA_W:1]};
        remain <= remain - 1'b1;
      end else if (start_now) begin
        busy   <= 1'b1;
        line_o <= 1'b0;
        shreg  <= {1'b1, hold_q};
        remain <= BCW'(DATA_W + 1);
      end else begin
        busy   <= 1'b0;
        line_o <= 1'b1;
      end
    end
  end

  assign ready_o = en_i & ~hold_full;
  assign work_o  = busy | hold_full;
endmodule

// File: rtl/chan_rx.sv
module chan_rx
  import chan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              ser_i,
  input  logic              ext_sel_i,
  input  logic              tick16_i,
  input  logic              ext_rise_i,
  output logic              push_o,
  output logic [DATA_W-1:0] pdata_o,
  output logic              pferr_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);

  rx_state_e       state;
  logic [CW-1:0]   tcnt;
  logic [BW-1:0]   nbits;
  logic [DATA_W-1:0] shreg;
  logic            samp;

  assign samp = ext_sel_i ? ext_rise_i : (tick16_i && tcnt == CW'(OVS / 2 - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      tcnt    <= '0;
      nbits   <= '0;
      shreg   <= '0;
      push_o  <= 1'b0;
      pdata_o <= '0;
      pferr_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (!en_i) begin
        state <= RX_IDLE;
      end else begin
        if (state != RX_IDLE && tick16_i) tcnt <= tcnt + 1'b1;
        case (state)
          RX_IDLE: begin
            if (ext_sel_i) begin
              if (ext_rise_i && !ser_i) begin
                state <= RX_DATA;
                nbits <= '0;
              end
            end else if (tick16_i && !ser_i) begin
              state <= RX_START;
              tcnt  <= '0;
            end
          end
          RX_START: begin
            if (samp) begin
              state <= ser_i ? RX_IDLE : RX_DATA;
              nbits <= '0;
            end
          end
          RX_DATA: begin
            if (samp) begin
              shreg <= {ser_i, shreg[DATA_W-1:1]};
              nbits <= nbits + 1'b1;
              if (nbits == BW'(DATA_W - 1)) state <= RX_STOP;
            end
          end
          RX_STOP: begin
            if (samp) begin
              push_o  <= 1'b1;
              pdata_o <= shreg;
              pferr_o <= ~ser_i;
              state   <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/chan_rxfifo.sv
// DEPTH must be a power of two.
module chan_rxfifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] pdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == (AW + 1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign ovf_o   = push_i && full_o;
  assign head_o  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= pdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/serial_chan.sv
module serial_chan #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              loopback_i,
  input  logic              tx_ext_sel_i,
  input  logic              rx_ext_sel_i,
  input  logic              ext_txclk_i,
  input  logic              ext_rxclk_i,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              cts_n_i,
  input  logic              rts_req_i,
  input  logic              rts_auto_tx_i,
  input  logic              rts_auto_rx_i,
  output logic              rts_n_o,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tx_ready_o,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_ferr_o,
  output logic              rx_ready_o,
  output logic              rx_full_o,
  output logic              overrun_o,
  input  logic              ovr_clr_i,
  input  logic              rx_irq_sel_i,
  output logic              rx_irq_n_o,
  output logic              tx_rdy_n_o
);
  localparam int FW = DATA_W + 1;

  logic tx_fall, rx_rise, tx_line, tx_work;
  logic cts_s1, cts_s2, ser_s1, ser_s2;
  logic push, pferr, empty, full, ovf;
  logic [DATA_W-1:0] pdata;
  logic [FW-1:0] head;

  chan_edge #(.RISING(1'b0)) u_txclk (
    .clk(clk), .rst(rst), .async_i(ext_txclk_i), .strobe_o(tx_fall));
  chan_edge #(.RISING(1'b1)) u_rxclk (
    .clk(clk), .rst(rst), .async_i(ext_rxclk_i), .strobe_o(rx_rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_s1 <= 1'b1;
      cts_s2 <= 1'b1;
      ser_s1 <= 1'b1;
      ser_s2 <= 1'b1;
    end else begin
      cts_s1 <= cts_n_i;
      cts_s2 <= cts_s1;
      ser_s1 <= loopback_i ? tx_line : rxd_i;
      ser_s2 <= ser_s1;
    end
  end

  chan_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .en_i(tx_en_i), .cts_n_i(cts_s2),
    .wr_i(wr_i), .wdata_i(wdata_i), .ext_sel_i(tx_ext_sel_i),
    .tick16_i(tick16_i), .ext_fall_i(tx_fall),
    .line_o(tx_line), .ready_o(tx_ready_o), .work_o(tx_work));

  chan_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .en_i(rx_en_i), .ser_i(ser_s2),
    .ext_sel_i(rx_ext_sel_i), .tick16_i(tick16_i), .ext_rise_i(rx_rise),
    .push_o(push), .pdata_o(pdata), .pferr_o(pferr));

  chan_rxfifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_i(push), .pdata_i({pferr, pdata}),
    .pop_i(rd_i), .head_o(head), .empty_o(empty), .full_o(full), .ovf_o(ovf));

  assign rdata_o    = head[DATA_W-1:0];
  assign rd_ferr_o  = head[DATA_W];
  assign rx_ready_o = ~empty;
  assign rx_full_o  = full;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_o      <= 1'b1;
      rts_n_o    <= 1'b1;
      overrun_o  <= 1'b0;
      rx_irq_n_o <= 1'b1;
      tx_rdy_n_o <= 1'b1;
    end else begin
      txd_o      <= loopback_i ? 1'b1 : tx_line;
      rts_n_o    <= ~((rts_req_i | (rts_auto_tx_i & tx_work)) & ~(rts_auto_rx_i & full));
      if (ovf) overrun_o <= 1'b1;
      else if (ovr_clr_i) overrun_o <= 1'b0;
      rx_irq_n_o <= ~(rx_irq_sel_i ? full : ~empty);
      tx_rdy_n_o <= ~tx_ready_o;
    end
  end
endmodule

// File: rtl/chan_chk.sv
module chan_chk (
  input logic clk,
  input logic rst,
  input logic loopback_i,
  input logic txd_o,
  input logic rx_ready_o,
  input logic rx_full_o,
  input logic overrun_o,
  input logic ovr_clr_i,
  input logic tx_ready_o,
  input logic wr_i,
  input logic rts_auto_rx_i,
  input logic rts_n_o
);
  assert_loop_mark_R11: assert property (@(posedge clk) disable iff (rst)
    (loopback_i && $past(loopback_i)) |-> txd_o);

  assert_full_implies_ready_R6: assert property (@(posedge clk) disable iff (rst)
    rx_full_o |-> rx_ready_o);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(overrun_o) && !$past(ovr_clr_i)) |-> overrun_o);

  assert_write_fills_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_ready_o && wr_i) |=> !tx_ready_o);

  assert_rts_full_drop_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rx_full_o && rts_auto_rx_i) |-> rts_n_o);
endmodule

bind serial_chan chan_chk chk_i (
  .clk(clk), .rst(rst), .loopback_i(loopback_i), .txd_o(txd_o),
  .rx_ready_o(rx_ready_o), .rx_full_o(rx_full_o), .overrun_o(overrun_o),
  .ovr_clr_i(ovr_clr_i), .tx_ready_o(tx_ready_o), .wr_i(wr_i),
  .rts_auto_rx_i(rts_auto_rx_i), .rts_n_o(rts_n_o));

// File: tb/serial_chan_tb_top.sv
`timescale 1ns/1ps
module serial_chan_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16_i = 1'b1;
  logic tx_en_i = 0, rx_en_i = 0, loopback_i = 0;
  logic tx_ext_sel_i = 0, rx_ext_sel_i = 0, ext_txclk_i = 0, ext_rxclk_i = 0;
  logic rxd_i = 1, cts_n_i = 0, rts_req_i = 0, rts_auto_tx_i = 0, rts_auto_rx_i = 0;
  logic wr_i = 0, rd_i = 0, ovr_clr_i = 0, rx_irq_sel_i = 0;
  logic [7:0] wdata_i = 0;
  logic txd_o, rts_n_o, tx_ready_o, rd_ferr_o, rx_ready_o, rx_full_o, overrun_o;
  logic rx_irq_n_o, tx_rdy_n_o;
  logic [7:0] rdata_o;

  int n_chk = 0, n_fail = 0;
  logic lb_bad = 0;

  always #2 clk = ~clk;

  serial_chan dut_i (.*);

  always @(negedge clk) if (loopback_i && txd_o == 1'b0) lb_bad <= 1'b1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic host_wr(input logic [7:0] b);
    wdata_i <= b; wr_i <= 1'b1; @(posedge clk); wr_i <= 1'b0;
  endtask

  task automatic host_rd();
    rd_i <= 1'b1; @(posedge clk); rd_i <= 1'b0; @(posedge clk);
  endtask

  task automatic wait_start(output logic got, input int tmo);
    got = 0;
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (txd_o == 1'b0) begin got = 1; break; end
    end
  endtask

  task automatic read_frame(output logic [7:0] b, output logic stopv);
    repeat (8) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      repeat (16) @(negedge clk);
      b[k] = txd_o;
    end
    repeat (16) @(negedge clk);
    stopv = txd_o;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stopb);
    rxd_i <= 1'b0; cyc(16);
    for (int k = 0; k < 8; k++) begin rxd_i <= b[k]; cyc(16); end
    rxd_i <= stopb; cyc(16);
    rxd_i <= 1'b1; cyc(4);
  endtask

  logic [7:0] tx_list [7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
  logic [7:0] rx_list [5] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h81};
  logic [7:0] q_list  [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h99};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic got, stopv, allone;
    logic [7:0] b;
    int chg, phase;
    logic v;
    logic bits [13];

    cyc(5);
    @(negedge clk);
    check(txd_o == 1, "R2 reset txd", txd_o, 1);
    check(rx_ready_o == 0, "R6 reset rx_ready", rx_ready_o, 0);
    check(overrun_o == 0, "R7 reset overrun", overrun_o, 0);
    check(rts_n_o == 1, "R12 reset rts_n", rts_n_o, 1);
    check(tx_ready_o == 0, "R8 disabled tx_ready", tx_ready_o, 0);
    @(posedge clk);
    rst <= 0; tx_en_i <= 1; rx_en_i <= 1;
    cyc(4);

    // R1: transmitter framing for several patterns
    foreach (tx_list[i]) begin
      host_wr(tx_list[i]);
      wait_start(got, 100);
      check(got, "R1 tx start", got, 1);
      read_frame(b, stopv);
      check(b == tx_list[i], "R1 tx data", b, tx_list[i]);
      check(stopv == 1, "R1 tx stop", stopv, 1);
    end
    cyc(40);
    allone = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (!txd_o) allone = 0; end
    check(allone, "R2 idle mark", allone, 1);

    // R3 / R8: CTS blocks start, second write ignored
    @(posedge clk); cts_n_i <= 1;
    cyc(4);
    host_wr(8'h96);
    @(negedge clk);
    check(tx_ready_o == 0, "R8 holding full", tx_ready_o, 0);
    @(posedge clk);
    host_wr(8'h11);
    allone = 1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd_o) allone = 0; end
    check(allone, "R3 cts blocks", allone, 1);
    check(tx_rdy_n_o == 1, "R13 tx_rdy_n while full", tx_rdy_n_o, 1);
    @(posedge clk); cts_n_i <= 0;
    wait_start(got, 100);
    read_frame(b, stopv);
    check(b == 8'h96, "R8 kept first write", b, 8'h96);
    wait_start(got, 400);
    check(!got, "R8 ignored second write", got, 0);
    @(negedge clk);
    check(tx_rdy_n_o == 0, "R13 tx_rdy_n empty", tx_rdy_n_o, 0);

    // R3: CTS rises mid character, character completes
    @(posedge clk); host_wr(8'hC3);
    wait_start(got, 100);
    cts_n_i <= 1;
    read_frame(b, stopv);
    check(b == 8'hC3 && stopv, "R3 in-progress completes", b, 8'hC3);
    @(posedge clk); cts_n_i <= 0;
    cyc(40);

    // R12: automatic RTS on transmit activity
    rts_auto_tx_i <= 1;
    host_wr(8'h42);
    cyc(3); @(negedge clk);
    check(rts_n_o == 0, "R12 rts active during tx", rts_n_o, 0);
    wait_start(got, 100);
    read_frame(b, stopv);
    cyc(40); @(negedge clk);
    check(rts_n_o == 1, "R12 rts dropped after tx", rts_n_o, 1);
    @(posedge clk); rts_auto_tx_i <= 0;

    // R1/R6: receiver with internal timing
    foreach (rx_list[i]) begin
      rx_send(rx_list[i], 1'b1);
      @(negedge clk);
      check(rx_ready_o == 1, "R6 rx_ready", rx_ready_o, 1);
      check(rdata_o == rx_list[i] && rd_ferr_o == 0, "R1 rx data", rdata_o, rx_list[i]);
      @(posedge clk); host_rd();
    end

    // R5: framing error
    rx_send(8'h3E, 1'b0);
    @(negedge clk);
    check(rdata_o == 8'h3E, "R5 data with ferr", rdata_o, 8'h3E);
    check(rd_ferr_o == 1, "R5 ferr flag", rd_ferr_o, 1);
    @(posedge clk); host_rd();
    cyc(200); @(negedge clk);
    check(rx_ready_o == 0, "R5 no spurious char", rx_ready_o, 0);

    // R4: noise pulse rejected
    @(posedge clk); rxd_i <= 0; cyc(4); rxd_i <= 1; cyc(200);
    @(negedge clk);
    check(rx_ready_o == 0, "R4 noise rejected", rx_ready_o, 0);

    // R6/R7/R12/R13: fill the buffer
    @(posedge clk); rts_req_i <= 1; rts_auto_rx_i <= 1; rx_irq_sel_i <= 0;
    rx_send(q_list[0], 1'b1);
    @(negedge clk);
    check(rx_irq_n_o == 0, "R13 irq ready mode", rx_irq_n_o, 0);
    check(rts_n_o == 0, "R12 rts active not full", rts_n_o, 0);
    @(posedge clk); rx_irq_sel_i <= 1; cyc(2); @(negedge clk);
    check(rx_irq_n_o == 1, "R13 irq full mode not full", rx_irq_n_o, 1);
    for (int i = 1; i < 4; i++) rx_send(q_list[i], 1'b1);
    @(negedge clk);
    check(rx_full_o == 1, "R6 full at four", rx_full_o, 1);
    check(rx_irq_n_o == 0, "R13 irq full mode full", rx_irq_n_o, 0);
    check(rts_n_o == 1, "R12 rts dropped on full", rts_n_o, 1);
    rx_send(q_list[4], 1'b1);
    @(negedge clk);
    check(overrun_o == 1, "R7 overrun set", overrun_o, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rdata_o == q_list[i], "R6 order", rdata_o, q_list[i]);
      @(posedge clk); host_rd();
      if (i == 0) begin
        @(negedge clk);
        check(rts_n_o == 0, "R12 rts back after read", rts_n_o, 0);
      end
    end
    @(negedge clk);
    check(rx_ready_o == 0, "R7 fifth discarded", rx_ready_o, 0);
    check(overrun_o == 1, "R7 overrun sticky", overrun_o, 1);
    @(posedge clk); host_rd();
    rx_send(8'h5C, 1'b1);
    @(negedge clk);
    check(rdata_o == 8'h5C && rx_ready_o && !rx_full_o, "R6 empty read ignored", rdata_o, 8'h5C);
    @(posedge clk); host_rd();
    ovr_clr_i <= 1; @(posedge clk); ovr_clr_i <= 0; @(negedge clk);
    check(overrun_o == 0, "R7 overrun cleared", overrun_o, 0);
    @(posedge clk); rts_req_i <= 0; rts_auto_rx_i <= 0; rx_irq_sel_i <= 0;

    // R9: external transmit clock, falling-edge launch
    tx_ext_sel_i <= 1; cyc(4);
    host_wr(8'hB4);
    chg = 0; phase = 0; stopv = 0; b = 0;
    for (int p = 0; p < 14; p++) begin
      @(negedge clk); v = txd_o; ext_txclk_i <= 1;
      if (phase == 0) begin if (!v) phase = 1; end
      else if (phase <= 8) begin b[phase-1] = v; phase++; end
      else if (phase == 9) begin stopv = v; phase = 10; end
      for (int k = 0; k < 16; k++) begin @(negedge clk); if (txd_o != v) chg++; end
      ext_txclk_i <= 0; repeat (15) @(negedge clk);
    end
    check(b == 8'hB4 && stopv, "R9 ext tx data", b, 8'hB4);
    check(chg == 0, "R9 no change while clock high", chg, 0);
    @(posedge clk); tx_ext_sel_i <= 0; cyc(40);

    // R10: external receive clock, rising-edge sampling
    rx_ext_sel_i <= 1; cyc(4);
    b = 8'h6D;
    bits[0] = 1; bits[1] = 1; bits[2] = 0;
    for (int k = 0; k < 8; k++) bits[3+k] = b[k];
    bits[11] = 1; bits[12] = 1;
    for (int k = 0; k < 13; k++) begin
      @(negedge clk); rxd_i <= bits[k];
      repeat (16) @(negedge clk); ext_rxclk_i <= 1;
      repeat (16) @(negedge clk); ext_rxclk_i <= 0;
    end
    cyc(4); @(negedge clk);
    check(rx_ready_o && rdata_o == 8'h6D && !rd_ferr_o, "R10 ext rx data", rdata_o, 8'h6D);
    @(posedge clk); host_rd();
    rx_ext_sel_i <= 0; cyc(40);

    // R11: loopback sweep of every code, rxd_i held low
    rxd_i <= 0; loopback_i <= 1; cyc(4);
    for (int c = 0; c < 256; c++) begin
      host_wr(8'(c));
      got = 0;
      for (int t = 0; t < 400; t++) begin
        @(negedge clk);
        if (rx_ready_o) begin got = 1; break; end
      end
      check(got && rdata_o == 8'(c) && !rd_ferr_o, "R11 loopback data", rdata_o, c);
      @(posedge clk); host_rd();
    end
    check(lb_bad == 0, "R11 txd held mark", lb_bad, 0);
    @(posedge clk); loopback_i <= 0; rxd_i <= 1; cyc(10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule